// File: doc/BRIEF.md
# Three-Channel Interval/Match PWM Timer

This block holds three independent timer channels. Each one produces a pulse-width-modulated output, for example to drive a cooling fan. Software programs each channel through a 32-bit word-addressed register bus. A channel counts ticks of its selected clock, optionally divided by a power-of-two prescaler. An interval value fixes the waveform period and a match value fixes the point where the output switches.

The tick source is either the system clock or an external clock pin. The external pin is brought into the clock domain through two flops and an edge detector, and either the rising or the falling edge can drive the count. A channel can count up or down. It either wraps at its interval value or runs over the full counter range. It can be frozen, restarted by a self-clearing command bit, inverted or forced to its idle level. Register accesses are single-cycle: a write takes effect at the clock edge where the request and write-enable are both high, and read data follows the address combinationally. There is no back-pressure on this bus. Control pins and the PWM outputs are plain level signals.

Top module: `tri_timer_pwm`

## Requirements
- R1: The register word index is a group base plus the channel number (0..2). The group bases are word 0 for tick setup, word 3 for run control, word 9 for interval and word 12 for match. Every other word reads 0, and writes to it are ignored. Read data is a combinational function of the address.
- R2: After reset, every tick-setup word reads 0, every run-control word reads 0x21 (halted, output off), interval and match read 0, and all PWM outputs are 0.
- R3: Interval and match keep only the low CW bits (default 16) of a write. The run-control restart bit (bit 4) always reads 0.
- R4: Writing run control with bit 4 set restarts the channel at that clock edge. The counter loads 0 when bit 2 is 0, or loads the interval value when bit 2 is 1, and the prescaler phase is cleared.
- R5: With run-control bit 1 set, an up count moves to 0 on the tick after it equals the interval value. A down count reloads the interval value on the tick after it reaches 0. The period is therefore interval+1 ticks.
- R6: With run-control bit 1 clear, the counter wraps over its full CW-bit range and ignores the interval value.
- R7: While run-control bit 0 is set, the counter holds its value and the output holds. Clearing the bit resumes counting from the held value.
- R8: Tick-setup bit 0 enables the prescaler and bits 4:1 hold N. When enabled, one count tick occurs per 2^(N+1) source events, the first one 2^(N+1) events after a restart. When disabled, every source event is a tick.
- R9: Tick-setup bit 5 makes edges of the external clock the source events. Bit 6 selects the falling edge instead of the rising edge. When bit 5 is clear, every system clock cycle is a source event.
- R10: With run-control bit 3 set, the raw level is high when the counter is at or above match (counting up) or at or below match (counting down). With bit 3 clear the raw level is 0. Run-control bit 6 inverts the raw level onto the output.
- R11: With run-control bit 5 set, the output equals the polarity bit (bit 6) whatever the counter holds.
- R12: The channels are independent: programming one channel changes neither the registers nor the output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Bus access request |
| reg_we | input | 1 | Write enable (with reg_req) |
| reg_addr | input | 4 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ext_clk | input | 1 | Asynchronous external tick clock |
| pwm_out | output | 3 | One waveform per channel |

## Verification
The assertions assume that the bus signals are stable around the sampling edge. They also assume that ext_clk stays at each level for at least three system clocks, so the synchronizer sees every edge and an edge pulse never lasts more than one cycle. The bench changes all inputs on the falling clock edge and holds ext_clk for four cycles per level. Interval and match are changed only while a channel is about to be restarted, so the wrap and reload properties see consistent values. Outputs are sampled on falling edges, after a count of the register stages from the write edge.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
  localparam int NCH = 3;
  localparam int AW  = 4;
  localparam int PW  = 4;

  // word bases of the register groups
  localparam int CLK_W = 0;
  localparam int CNT_W = 3;
  localparam int IVL_W = 9;
  localparam int MAT_W = 12;

  // run-control bit positions used by the decoder
  localparam int B_DOWN = 2;
  localparam int B_RST  = 4;

  typedef struct packed {
    logic          fall;   // bit 6
    logic          ext;    // bit 5
    logic [PW-1:0] pdiv;   // bits 4:1
    logic          pen;    // bit 0
  } clk_cfg_t;

  typedef struct packed {
    logic pol;      // bit 6
    logic wdis;     // bit 5
    logic restart;  // bit 4
    logic men;      // bit 3
    logic down;     // bit 2
    logic imode;    // bit 1
    logic stop;     // bit 0
  } cnt_cfg_t;

  localparam cnt_cfg_t CNT_RST = cnt_cfg_t'(7'h21);
endpackage

// File: rtl/tpw_regs.sv
module tpw_regs
  import tpw_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output clk_cfg_t [NCH-1:0]       clk_cfg,
  output cnt_cfg_t [NCH-1:0]       cnt_cfg,
  output logic [NCH-1:0][CW-1:0]   intv,
  output logic [NCH-1:0][CW-1:0]   mtch,
  output logic [NCH-1:0]           restart,
  output logic [NCH-1:0]           restart_dn
);
  logic wr;
  logic unused_hi;
  assign wr = req & we;
  assign unused_hi = ^wdata[31:7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int ch = 0; ch < NCH; ch++) begin
        clk_cfg[ch] <= '0;
        cnt_cfg[ch] <= CNT_RST;
        intv[ch]    <= '0;
        mtch[ch]    <= '0;
      end
    end else if (wr) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (addr == AW'(CLK_W + ch)) clk_cfg[ch] <= clk_cfg_t'(wdata[6:0]);
        if (addr == AW'(CNT_W + ch))
          cnt_cfg[ch] <= cnt_cfg_t'({wdata[6:5], 1'b0, wdata[3:0]});
        if (addr == AW'(IVL_W + ch)) intv[ch] <= wdata[CW-1:0];
        if (addr == AW'(MAT_W + ch)) mtch[ch] <= wdata[CW-1:0];
      end
    end
  end

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      restart[ch]    = wr && (addr == AW'(CNT_W + ch)) && wdata[B_RST];
      restart_dn[ch] = wdata[B_DOWN];
    end
  end

  always_comb begin
    rdata = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (addr == AW'(CLK_W + ch)) rdata = {25'b0, clk_cfg[ch]};
      if (addr == AW'(CNT_W + ch)) rdata = {25'b0, cnt_cfg[ch]};
      if (addr == AW'(IVL_W + ch)) rdata = 32'(intv[ch]);
      if (addr == AW'(MAT_W + ch)) rdata = 32'(mtch[ch]);
    end
  end

  // R3: the restart command never lingers in the stored control word
  a_r3_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (restart != '0) |=> (cnt_cfg[0].restart == 1'b0 && cnt_cfg[1].restart == 1'b0
                         && cnt_cfg[2].restart == 1'b0));
endmodule

// File: rtl/tpw_tick.sv
module tpw_tick
  import tpw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ext_in,
  input  clk_cfg_t cfg,
  input  logic     restart,
  output logic     tick
);
  localparam int DW = (1 << PW) + 1;

  logic          s1, s2, s3;
  logic          rise, fall, src;
  logic [DW-1:0] pcnt, lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {ext_in, s1, s2};
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
  assign src  = cfg.ext ? (cfg.fall ? fall : rise) : 1'b1;
  assign lim  = (DW'(2) << cfg.pdiv) - DW'(1);
  assign tick = src & (~cfg.pen | (pcnt == lim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt <= '0;
    else if (restart)          pcnt <= '0;
    else if (src && cfg.pen)   pcnt <= (pcnt == lim) ? '0 : pcnt + DW'(1);
  end

  // R9: a synchronized edge yields a single-cycle pulse
  a_r9_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  a_r9_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
  // R4: restart clears the prescaler phase
  a_r4_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pcnt == '0));
endmodule

// File: rtl/tpw_chan.sv
module tpw_chan
  import tpw_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cnt_cfg_t      cfg,
  input  logic [CW-1:0] intv,
  input  logic [CW-1:0] mtch,
  input  logic          tick,
  input  logic          restart,
  input  logic          restart_dn,
  output logic          pwm
);
  logic [CW-1:0] cnt;
  logic          level;
  logic          unused_rst;
  assign unused_rst = cfg.restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart) cnt <= restart_dn ? intv : '0;
    else if (tick && !cfg.stop) begin
      if (!cfg.down)
        cnt <= (cfg.imode && cnt == intv) ? '0 : cnt + CW'(1);
      else if (cnt == '0)
        cnt <= cfg.imode ? intv : '1;
      else
        cnt <= cnt - CW'(1);
    end
  end

  assign level = cfg.men & (cfg.down ? (cnt <= mtch) : (cnt >= mtch));
  assign pwm   = cfg.wdis ? cfg.pol : (level ^ cfg.pol);

  // R4: restart loads zero or the interval
  a_r4_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == $past(restart_dn ? intv : '0)));
  // R7: a halted counter holds
  a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cfg.stop) |=> $stable(cnt));
  // R5: up count wraps after the interval value
  a_r5_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && tick && !cfg.stop && !cfg.down && cfg.imode && cnt == intv)
      |=> (cnt == '0));
  // R5: down count reloads the interval after zero
  a_r5_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && tick && !cfg.stop && cfg.down && cfg.imode && cnt == '0)
      |=> (cnt == $past(intv)));
endmodule

// File: rtl/tri_timer_pwm.sv
module tri_timer_pwm
  import tpw_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_req,
  input  logic           reg_we,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           ext_clk,
  output logic [2:0]     pwm_out
);
  clk_cfg_t [NCH-1:0]     clk_cfg;
  cnt_cfg_t [NCH-1:0]     cnt_cfg;
  logic [NCH-1:0][CW-1:0] intv, mtch;
  logic [NCH-1:0]         restart, restart_dn, tick;

  tpw_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(reg_req), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .clk_cfg(clk_cfg), .cnt_cfg(cnt_cfg),
    .intv(intv), .mtch(mtch), .restart(restart), .restart_dn(restart_dn)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tpw_tick u_tick (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_clk), .cfg(clk_cfg[ch]),
      .restart(restart[ch]), .tick(tick[ch])
    );
    tpw_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .cfg(cnt_cfg[ch]), .intv(intv[ch]),
      .mtch(mtch[ch]), .tick(tick[ch]), .restart(restart[ch]),
      .restart_dn(restart_dn[ch]), .pwm(pwm_out[ch])
    );
  end
endmodule

// File: tb/tri_timer_pwm_test.sv
module tri_timer_pwm_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_req = 0, reg_we = 0, ext_clk = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [2:0]  pwm_out;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  tri_timer_pwm uut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_clk(ext_clk), .pwm_out(pwm_out)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // returns one ns after the write edge
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk);
    #1 reg_req = 0; reg_we = 0;
  endtask

  task automatic rd_chk(string tag, int a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 chk(tag, reg_rdata, exp);
  endtask

  function automatic logic model(int k, int iv, int m, bit dn, bit pol, int d);
    int c;
    c = (k / d) % (iv + 1);
    if (dn) c = iv - c;
    return (dn ? (c <= m) : (c >= m)) ^ pol;
  endfunction

  // k-th falling edge after the write edge sees the count after k edges
  task automatic run_chk(string tag, int ch, int kmax, int iv, int m, bit dn, bit pol, int d);
    for (int k = 0; k <= kmax; k++) begin
      @(negedge clk);
      chk(tag, 32'(pwm_out[ch]), 32'(model(k, iv, m, dn, pol, d)));
    end
  endtask

  task automatic setup(int ch, int iv, int m, int ck);
    wr(0 + ch, 32'(ck));
    wr(9 + ch, 32'(iv));
    wr(12 + ch, 32'(m));
  endtask

  task automatic ext_pulse();
    @(negedge clk) ext_clk = 1;
    repeat (4) @(negedge clk);
    ext_clk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R2 clk reset", 0, 0);
    rd_chk("R2 ctrl reset", 4, 32'h21);
    rd_chk("R2 interval reset", 11, 0);
    chk("R2 pwm reset", 32'(pwm_out), 0);
  endtask

  task automatic t_indep();
    setup(1, 5, 0, 0);
    wr(4, 32'h1A);                       // ch1 up, match 0 -> always high
    repeat (3) @(negedge clk);
    chk("R12 ch1 runs", 32'(pwm_out[1]), 1);
    chk("R12 ch0 idle", 32'(pwm_out[0]), 0);
    chk("R12 ch2 idle", 32'(pwm_out[2]), 0);
    rd_chk("R12 ch0 ctrl untouched", 3, 32'h21);
  endtask

  task automatic t_regs();
    wr(10, 32'h12345);
    rd_chk("R3 interval truncated", 10, 32'h2345);
    wr(5, 32'h31);
    rd_chk("R3 restart reads 0", 5, 32'h21);
    wr(6, 32'hFFFF);
    rd_chk("R1 unmapped word", 6, 0);
    rd_chk("R1 top word", 15, 0);
    rd_chk("R1 match group ch2", 14, 0);
  endtask

  task automatic t_up();
    setup(0, 9, 4, 0);
    wr(3, 32'h1A);
    run_chk("R5 R10 up interval", 0, 30, 9, 4, 0, 0, 1);
  endtask

  task automatic t_down();
    setup(0, 7, 2, 0);
    wr(3, 32'h1E);
    run_chk("R4 R5 down interval", 0, 25, 7, 2, 1, 0, 1);
  endtask

  task automatic t_pol();
    setup(0, 6, 3, 0);
    wr(3, 32'h5A);
    run_chk("R10 inverted", 0, 20, 6, 3, 0, 1, 1);
  endtask

  task automatic t_presc();
    setup(1, 3, 2, 32'h03);              // enable, N=1 -> /4
    wr(4, 32'h1A);
    run_chk("R8 prescale by 4", 1, 40, 3, 2, 0, 0, 4);
  endtask

  task automatic t_stop();
    logic expv [4] = '{1, 1, 1, 0};
    setup(0, 9, 5, 0);
    wr(3, 32'h1A);
    run_chk("R7 pre-stop", 0, 5, 9, 5, 0, 0, 1);
    wr(3, 32'h0B);                       // halt on the 7th edge: count 7
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R7 held", 32'(pwm_out[0]), 1);
    end
    wr(3, 32'h0A);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 resume", 32'(pwm_out[0]), 32'(expv[i]));
    end
  endtask

  task automatic t_dis();
    setup(0, 4, 1, 0);
    wr(3, 32'h3A);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R11 disabled low", 32'(pwm_out[0]), 0);
    end
    wr(3, 32'h7A);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R11 disabled inverted", 32'(pwm_out[0]), 1);
    end
  endtask

  task automatic t_nomatch();
    setup(0, 4, 0, 0);
    wr(3, 32'h12);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R10 no match low", 32'(pwm_out[0]), 0);
    end
    wr(3, 32'h52);
    @(negedge clk);
    chk("R10 no match inverted", 32'(pwm_out[0]), 1);
  endtask

  task automatic t_free();
    setup(2, 3, 5, 0);
    wr(5, 32'h18);                       // up, full range
    for (int k = 0; k <= 12; k++) begin
      @(negedge clk);
      chk("R6 free up", 32'(pwm_out[2]), 32'(k >= 5));
    end
    setup(2, 2, 5, 0);
    wr(5, 32'h1C);                       // down, full range: 2,1,0,FFFF..
    for (int k = 0; k <= 12; k++) begin
      @(negedge clk);
      chk("R6 free down", 32'(pwm_out[2]), 32'(k <= 2));
    end
  endtask

  task automatic t_ext();
    ext_clk = 0;
    setup(0, 15, 3, 32'h20);             // rising edges of ext_clk
    wr(3, 32'h1A);
    ext_pulse(); ext_pulse();
    chk("R9 ext rise two edges", 32'(pwm_out[0]), 0);
    ext_pulse();
    chk("R9 ext rise three edges", 32'(pwm_out[0]), 1);
    setup(0, 15, 3, 32'h60);             // falling edges
    wr(3, 32'h1A);
    ext_pulse(); ext_pulse();
    @(negedge clk) ext_clk = 1;
    repeat (6) @(negedge clk);
    chk("R9 ext fall ignores rise", 32'(pwm_out[0]), 0);
    ext_clk = 0;
    repeat (6) @(negedge clk);
    chk("R9 ext fall counts", 32'(pwm_out[0]), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_indep();
    t_regs();
    t_up();
    t_down();
    t_pol();
    t_presc();
    t_stop();
    t_dis();
    t_nomatch();
    t_free();
    t_ext();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule